// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level and holds stores that have not yet reached memory. Each entry covers one aligned block of `WORDS` words: a block tag, the word data and a mask of which words hold buffered data. A store whose block already has a pending entry writes into that entry, so one memory transaction can carry several stores. Only when the block has no entry it can use does the store take a new one.

Entries go to memory one at a time, oldest first. The oldest entry is always the one offered to memory, and it stays locked against merging until memory acknowledges it. A store to the locked block opens a new, younger entry. A separate lookup port lets a read miss search the buffer before going to memory. It returns the newest buffered copy of the word. If the block is buffered but that word is not, it raises a wait flag. The store port stalls only when every slot is taken, the store cannot merge, and no slot is freed in the same cycle.

Top module: `wrBufMerge`

## Requirements
- R1: After reset the buffer is empty. `memReq`, `rdHit` and `rdWait` are low and `stReady` is high.
- R2: An accepted store whose block has no mergeable entry takes a new entry. When that entry is offered, `memAddr` is the block address `stAddr[ADDR_W-1:log2(WORDS)]`. `memMask` has only bit `o` set, where `o = stAddr[log2(WORDS)-1:0]`. The stored word appears in `memData[o*DATA_W +: DATA_W]` and the other words are zero.
- R3: A store to the block of a pending entry that is not the oldest entry writes its word into that entry and sets its mask bit. A later store to the same word replaces the data. No new entry is taken.
- R4: `memReq` is high exactly while the buffer holds at least one entry. The oldest entry is presented and held stable until a cycle with `memReq` and `memAck` both high, which removes it. Entries drain in the order they were created.
- R5: The entry currently presented to memory is never merged into, even in a cycle where `memAck` is high. A store to its block takes a new entry, which drains later.
- R6: `stReady` is low only when all `DEPTH` entries are in use, no non-oldest entry matches the store's block, and `memAck` is not high. A store to a matching non-oldest entry is accepted even when all entries are in use.
- R7: When all entries are in use and a non-merging store arrives in the same cycle as `memAck`, the store is accepted in that cycle and drains after all older entries.
- R8: The lookup port raises `rdHit` when some entry for `rdAddr`'s block has that word's mask bit set. `rdData` is then the word from the youngest such entry.
- R9: When entries exist for `rdAddr`'s block but none has that word's mask bit set, `rdWait` is high and `rdHit` is low.
- R10: When no entry holds `rdAddr`'s block, `rdHit` and `rdWait` are both low. The lookup sees only stores accepted in earlier cycles.
- R11: A store offered while `stReady` is low has no effect. It creates no entry and changes no buffered data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data word |
| stReady | output | 1 | Store accepted this cycle when high with stValid |
| memReq | output | 1 | Oldest entry offered to memory |
| memAddr | output | ADDR_W-log2(WORDS) | Block address of offered entry |
| memData | output | WORDS*DATA_W | Word data of offered entry, word i at bits i*DATA_W |
| memMask | output | WORDS | Valid words of offered entry |
| memAck | input | 1 | Memory takes the offered entry |
| rdAddr | input | ADDR_W | Read-miss lookup word address |
| rdHit | output | 1 | Lookup word found in buffer |
| rdData | output | DATA_W | Newest buffered copy of the lookup word |
| rdWait | output | 1 | Block buffered but word absent; caller waits for drain |

## Verification
The hardest conditions to reach are the ones at the edges of a drain. One is a full buffer where a new-block store meets an acknowledge in the same cycle. Another is a store to the locked oldest block while that entry is being acknowledged. The stimulus reaches them by holding `memAck` low through enough distinct-block stores to fill every slot. It then raises `memAck` in the same cycle as a refused store, a merge into a younger entry, and a new-block store. A long mixed phase over a few blocks, with irregular acknowledges, repeatedly places a store to the head block on the acknowledge cycle. During that phase, lookups check youngest-copy priority between the draining entry and its younger twin.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
  // Strobes issued by control to the datapath each cycle.
  typedef struct packed {
    logic allocEn;   // open new entry at allocIdx
    logic mergeEn;   // write word into entry at mergeIdx
    logic popEn;     // retire entry at headIdx
  } wbStrobe_t;
endpackage

// File: rtl/wrbuf_ctrl.sv
module wrbuf_ctrl
  import wrbuf_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       stValid,
  input  logic                       memAck,
  input  logic [DEPTH-1:0]           tagHitVec,
  output wbStrobe_t                  strobe,
  output logic [$clog2(DEPTH)-1:0]   allocIdx,
  output logic [$clog2(DEPTH)-1:0]   mergeIdx,
  output logic [$clog2(DEPTH)-1:0]   headIdx,
  output logic                       stReady,
  output logic                       memReq
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] countQ;
  logic [IDX_W-1:0] headQ;
  logic [DEPTH-1:0] headOh;
  logic [DEPTH-1:0] mergeCand;
  logic             mergeHit;
  logic             fullQ;
  logic             popOk;

  assign headIdx  = headQ;
  assign memReq   = (countQ != '0);
  assign fullQ    = (countQ == CNT_W'(DEPTH));
  assign popOk    = memAck && memReq;
  assign headOh   = DEPTH'(1) << headQ;
  assign mergeCand = tagHitVec & ~headOh;
  assign mergeHit = |mergeCand;
  assign stReady  = mergeHit || !fullQ || popOk;

  always_comb begin
    mergeIdx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (mergeCand[i]) mergeIdx = IDX_W'(i);
  end

  always_comb begin
    if (int'(headQ) + int'(countQ) >= DEPTH)
      allocIdx = headQ - IDX_W'(DEPTH - int'(countQ));
    else
      allocIdx = headQ + IDX_W'(countQ);
  end

  always_comb begin
    strobe.mergeEn = stValid && mergeHit;
    strobe.allocEn = stValid && !mergeHit && (!fullQ || popOk);
    strobe.popEn   = popOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      headQ  <= '0;
    end else begin
      countQ <= countQ + CNT_W'(strobe.allocEn) - CNT_W'(strobe.popEn);
      if (strobe.popEn)
        headQ <= (headQ == IDX_W'(DEPTH - 1)) ? '0 : headQ + 1'b1;
    end
  end
endmodule

// File: rtl/wrbuf_data.sv
module wrbuf_data
  import wrbuf_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  wbStrobe_t                         strobe,
  input  logic [$clog2(DEPTH)-1:0]          allocIdx,
  input  logic [$clog2(DEPTH)-1:0]          mergeIdx,
  input  logic [$clog2(DEPTH)-1:0]          headIdx,
  input  logic [ADDR_W-1:0]                 stAddr,
  input  logic [DATA_W-1:0]                 stData,
  input  logic [ADDR_W-1:0]                 rdAddr,
  output logic [DEPTH-1:0]                  tagHitVec,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   memAddr,
  output logic [WORDS*DATA_W-1:0]           memData,
  output logic [WORDS-1:0]                  memMask,
  output logic                              rdHit,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              rdWait
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]                   tagQ  [DEPTH];
  logic [WORDS-1:0][DATA_W-1:0]       dataQ [DEPTH];
  logic [WORDS-1:0]                   maskQ [DEPTH];
  logic [DEPTH-1:0]                   vldQ;

  logic [TAG_W-1:0] stTag, rdTag;
  logic [OFF_W-1:0] stOff, rdOff;
  assign stTag = stAddr[ADDR_W-1:OFF_W];
  assign stOff = stAddr[OFF_W-1:0];
  assign rdTag = rdAddr[ADDR_W-1:OFF_W];
  assign rdOff = rdAddr[OFF_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : gHit
    assign tagHitVec[g] = vldQ[g] && (tagQ[g] == stTag);
  end

  assign memAddr = tagQ[headIdx];
  assign memData = dataQ[headIdx];
  assign memMask = maskQ[headIdx];

  // Age-ordered scan: a younger entry holding the word overrides older ones.
  always_comb begin
    logic             seen;
    logic [IDX_W-1:0] slot;
    seen   = 1'b0;
    rdHit  = 1'b0;
    rdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(headIdx) >= DEPTH - k) slot = headIdx - IDX_W'(DEPTH - k);
      else                            slot = headIdx + IDX_W'(k);
      if (vldQ[slot] && (tagQ[slot] == rdTag)) begin
        seen = 1'b1;
        if (maskQ[slot][rdOff]) begin
          rdHit  = 1'b1;
          rdData = dataQ[slot][rdOff];
        end
      end
    end
    rdWait = seen && !rdHit;
  end

  always_ff @(posedge clk) begin
    if (strobe.mergeEn) begin
      dataQ[mergeIdx][stOff] <= stData;
      maskQ[mergeIdx][stOff] <= 1'b1;
    end
    if (strobe.allocEn) begin
      tagQ[allocIdx]         <= stTag;
      dataQ[allocIdx]        <= '0;
      dataQ[allocIdx][stOff] <= stData;
      maskQ[allocIdx]        <= '0;
      maskQ[allocIdx][stOff] <= 1'b1;
    end
  end

  // Allocation after retirement: a full-buffer refill reuses the freed slot.
  always_ff @(posedge clk) begin
    if (!rstN) vldQ <= '0;
    else begin
      if (strobe.popEn)   vldQ[headIdx]  <= 1'b0;
      if (strobe.allocEn) vldQ[allocIdx] <= 1'b1;
    end
  end
endmodule

// File: rtl/wrBufMerge.sv
module wrBufMerge
  import wrbuf_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              stValid,
  input  logic [ADDR_W-1:0]                 stAddr,
  input  logic [DATA_W-1:0]                 stData,
  output logic                              stReady,
  output logic                              memReq,
  output logic [ADDR_W-$clog2(WORDS)-1:0]   memAddr,
  output logic [WORDS*DATA_W-1:0]           memData,
  output logic [WORDS-1:0]                  memMask,
  input  logic                              memAck,
  input  logic [ADDR_W-1:0]                 rdAddr,
  output logic                              rdHit,
  output logic [DATA_W-1:0]                 rdData,
  output logic                              rdWait
);
  localparam int IDX_W = $clog2(DEPTH);

  wbStrobe_t        strobe;
  logic [DEPTH-1:0] tagHitVec;
  logic [IDX_W-1:0] allocIdx, mergeIdx, headIdx;

  wrbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .memAck(memAck),
    .tagHitVec(tagHitVec), .strobe(strobe), .allocIdx(allocIdx),
    .mergeIdx(mergeIdx), .headIdx(headIdx), .stReady(stReady), .memReq(memReq)
  );

  wrbuf_data #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .mergeIdx(mergeIdx), .headIdx(headIdx), .stAddr(stAddr), .stData(stData),
    .rdAddr(rdAddr), .tagHitVec(tagHitVec), .memAddr(memAddr), .memData(memData),
    .memMask(memMask), .rdHit(rdHit), .rdData(rdData), .rdWait(rdWait)
  );
endmodule

// File: rtl/wrBufMerge_chk.sv
module wrBufMerge_chk #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              stValid,
  input logic                              stReady,
  input logic                              memReq,
  input logic [ADDR_W-$clog2(WORDS)-1:0]   memAddr,
  input logic [WORDS*DATA_W-1:0]           memData,
  input logic [WORDS-1:0]                  memMask,
  input logic                              memAck,
  input logic                              rdHit,
  input logic                              rdWait
);
  AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    stValid && stReady |=> memReq);                                      // R2
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr));                   // R4
  AST_HEAD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memData) && $stable(memMask));         // R5
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !stReady |-> memReq && !memAck);                                     // R6
  AST_HIT_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdHit && rdWait));                                                 // R9
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> !rdHit && !rdWait);                                      // R10
endmodule

bind wrBufMerge wrBufMerge_chk #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady), .memReq(memReq),
  .memAddr(memAddr), .memData(memData), .memMask(memMask), .memAck(memAck),
  .rdHit(rdHit), .rdWait(rdWait)
);

// File: tb/wrBufMerge_test.sv
`timescale 1ns/1ps
module wrBufMerge_test;
  localparam int DEPTH  = 10;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, memAck = 1'b0;
  logic [ADDR_W-1:0] stAddr = '0, rdAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic stReady, memReq, rdHit, rdWait;
  logic [TAG_W-1:0] memAddr;
  logic [WORDS*DATA_W-1:0] memData;
  logic [WORDS-1:0] memMask;
  logic [DATA_W-1:0] rdData;

  always #10 clk = ~clk;

  wrBufMerge #(.DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stReady(stReady), .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memMask(memMask), .memAck(memAck), .rdAddr(rdAddr), .rdHit(rdHit),
    .rdData(rdData), .rdWait(rdWait)
  );

  int nChecks = 0, nFails = 0;
  bit running = 0, done = 0;
  int preSize = 0;
  string curTag = "R2";

  // Expected entries, oldest first.
  int                      qA[$];
  logic [WORDS*DATA_W-1:0] qD[$];
  logic [WORDS-1:0]        qM[$];

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, lookup check and model update.
  task automatic step(input logic v, input int blk, input int off, input logic [31:0] d,
                      input logic ack, input int rblk, input int roff);
    int mergeAt;
    bit expReady, seen, hit;
    logic [DATA_W-1:0] expDat;
    logic [WORDS*DATA_W-1:0] tmp;
    string rq;
    @(negedge clk);
    stValid = v; stAddr = ADDR_W'(blk * WORDS + off); stData = d; memAck = ack;
    rdAddr = ADDR_W'(rblk * WORDS + roff);
    #1;
    preSize = qA.size();
    seen = 0; hit = 0; expDat = '0;
    foreach (qA[j]) if (qA[j] == rblk) begin
      seen = 1;
      if (qM[j][roff]) begin hit = 1; expDat = qD[j][roff*DATA_W +: DATA_W]; end
    end
    rq = hit ? "R8" : (seen ? "R9" : "R10");
    check(rq, "rdHit", 128'(rdHit), 128'(hit));
    check(rq, "rdWait", 128'(rdWait), 128'(seen && !hit));
    if (hit) check(rq, "rdData", 128'(rdData), 128'(expDat));
    mergeAt = -1;
    for (int j = 1; j < qA.size(); j++) if (qA[j] == blk) mergeAt = j;
    expReady = (mergeAt >= 0) || (preSize < DEPTH) || (ack && preSize > 0);
    if (v) begin
      check((preSize == DEPTH && ack) ? "R7" : "R6", "stReady", 128'(stReady), 128'(expReady));
      if (expReady) begin
        if (mergeAt >= 0) begin
          tmp = qD[mergeAt]; tmp[off*DATA_W +: DATA_W] = d; qD[mergeAt] = tmp;
          qM[mergeAt][off] = 1'b1;
        end else begin
          tmp = '0; tmp[off*DATA_W +: DATA_W] = d;
          qA.push_back(blk); qD.push_back(tmp); qM.push_back(WORDS'(1) << off);
        end
      end
    end
  endtask

  // Monitor: compares the drained entry against the oldest expected item.
  initial forever begin
    @(negedge clk); #2;
    if (running) begin
      check("R4", "memReq", 128'(memReq), 128'(preSize != 0));
      if (memReq && memAck && qA.size() > 0) begin
        check(curTag, "memAddr", 128'(memAddr), 128'(qA[0]));
        check(curTag, "memData", 128'(memData), 128'(qD[0]));
        check(curTag, "memMask", 128'(memMask), 128'(qM[0]));
        void'(qA.pop_front()); void'(qD.pop_front()); void'(qM.pop_front());
      end
    end
  end

  task automatic drainAll();
    for (int i = 0; i < 40 && qA.size() > 0; i++) step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    check(curTag, "model empty", 128'(qA.size()), 128'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1", "memReq", 128'(memReq), 128'(0));
    check("R1", "stReady", 128'(stReady), 128'(1));
    check("R1", "rdHit", 128'(rdHit), 128'(0));
    check("R1", "rdWait", 128'(rdWait), 128'(0));
    running = 1;

    // R2: single store, held then drained
    curTag = "R2";
    step(1, 5, 1, 32'hA1A1_0001, 0, 5, 1);
    step(0, 0, 0, 0, 0, 5, 1);
    step(0, 0, 0, 0, 0, 5, 2);
    drainAll();

    // R3: merge into younger entry, overwrite; R8/R9/R10 lookups
    curTag = "R3";
    step(1, 7, 0, 32'h7000_0000, 0, 0, 0);
    step(1, 8, 2, 32'h8000_0002, 0, 0, 0);
    step(1, 8, 1, 32'h8000_0001, 0, 8, 2);
    step(1, 8, 2, 32'h8222_2222, 0, 8, 1);
    step(0, 0, 0, 0, 0, 8, 2);   // R8 newest word
    step(0, 0, 0, 0, 0, 8, 3);   // R9 partial block
    step(0, 0, 0, 0, 0, 9, 0);   // R10 absent block
    drainAll();

    // R5: head locked, also on ack cycle; R8 youngest copy wins
    curTag = "R5";
    step(1, 3, 0, 32'h3000_0000, 0, 0, 0);
    step(1, 3, 1, 32'h3000_0001, 0, 3, 0);
    step(1, 3, 0, 32'h3333_0000, 0, 3, 1);
    step(0, 0, 0, 0, 0, 3, 0);
    step(1, 4, 0, 32'h4000_0000, 0, 0, 0);
    step(1, 4, 2, 32'h4000_0002, 1, 4, 2);
    step(1, 4, 3, 32'h4000_0003, 1, 4, 3);
    drainAll();

    // R6/R11/R7: fill, refuse, merge when full, store with ack
    curTag = "R6";
    for (int b = 0; b < DEPTH; b++) step(1, 20 + b, 0, 32'h2000_0000 + b, 0, 0, 0);
    curTag = "R11";
    step(1, 40, 0, 32'hDEAD_0040, 0, 40, 0);
    step(0, 0, 0, 0, 0, 40, 0);
    curTag = "R6";
    step(1, 25, 3, 32'h2500_0003, 0, 25, 3);
    curTag = "R7";
    step(1, 41, 1, 32'h4100_0001, 1, 41, 1);
    step(1, 42, 2, 32'hDEAD_0042, 0, 0, 0);
    step(1, 20, 1, 32'h2000_0001, 1, 20, 1);
    drainAll();

    // Mixed traffic over few blocks
    curTag = "R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], 50 + int'(lfsr[4:2] % 3'd5), int'(lfsr[6:5]),
           {lfsr, lfsr ^ 16'h5A5A}, lfsr[7] & lfsr[8],
           50 + int'(lfsr[11:9] % 3'd5), int'(lfsr[13:12]));
    end
    drainAll();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule